// File: doc/BRIEF.md
# SD Card SPI Command Framer

This block issues a single command to an SD card running in SPI mode and returns the card's one-byte reply. The host supplies a 6-bit command index and a 32-bit argument, then pulses `start`. The block lowers chip select and shifts out a six-byte frame. The last byte of that frame holds a CRC-7 that the block works out in hardware while the earlier bytes are being loaded. The block then keeps clocking `0xFF` onto the bus until a reply byte arrives or until a fixed budget of poll bytes runs out. It closes the transaction with chip select high and eight clocks of ones on MOSI, and finally pulses `done`.

The SPI side uses mode 0. SCK idles low, and both the outgoing and the incoming bit are taken on the rising edge. Traffic is aligned to byte boundaries. The SCK rate comes from an external half-period setting, which must stay constant during a transaction. Data-block transfers, card start-up sequencing and clock-rate policy belong to the surrounding logic.

Top module: `sd_cmd_framer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 1, `done` is 0, `timeout` is 0 and `reply` is 0xFF.
- R2: The first transmitted byte is `{2'b01, cmd_idx}`, i.e. the index ORed with 0x40.
- R3: Bytes two to five carry `cmd_arg` with the most significant byte first. The argument is captured at `start`.
- R4: Byte six holds in bits 7..1 the CRC-7 of bytes one to five (generator x^7+x^3+1, register cleared to zero, data fed MSB first), and bit 0 is 1. For index 0 with argument 0 this byte is 0x95.
- R5: In SPI mode 0 with MSB first, SCK idles low, MISO is sampled on the rising SCK edge, and each SCK high phase lasts `div_half`+1 clock cycles.
- R6: After the frame, the block sends poll bytes of 0xFF with chip select low. Bytes received while the frame itself is being sent are never taken as the reply.
- R7: The reply is the first poll byte whose bit 7 is 0. Poll bytes with bit 7 set are skipped, and polling stops after the reply byte.
- R8: If none of the first 8 poll bytes has bit 7 clear, `timeout` is set to 1, `reply` is 0xFF and the transaction ends after exactly 8 poll bytes.
- R9: Chip select is low from the first frame bit through the last poll byte. It rises before the trailing byte, which is exactly 8 SCK rising edges with chip select high and MOSI 1.
- R10: `done` is a one-cycle pulse after the trailing clocks. `reply` and `timeout` are valid at that pulse and hold until the next accepted `start`.
- R11: A `start` pulse during a transaction, or a change of `cmd_idx` or `cmd_arg` during one, has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| div_half | input | DIV_W | SCK half-period minus one, in clock cycles |
| done | output | 1 | One-cycle end-of-transaction pulse |
| reply | output | 8 | Reply byte received from the card |
| timeout | output | 1 | No reply within the poll budget |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |

## Verification
The bench sweeps six index and argument pairs. These include all-zero and all-one arguments and a pair with a known CRC byte, which separates byte ordering errors from CRC polynomial or augmentation errors. For each pair, the reply delay runs from zero to nine poll bytes. Delays seven and eight fall on either side of the timeout boundary. Before the reply, the card model sends filler bytes with bit 7 set but different low bits, which shows that only the top bit decides acceptance. On alternate runs it drives zeros during the frame, which shows that frame-time input is ignored. The half-period setting rotates through three values, and every run also carries a spurious `start` pulse with changed inputs, so timing scaling and input capture are checked alongside framing.

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
  parameter int DIV_W    = 8,
  parameter int MAX_POLL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       cmd_idx,
  input  logic [31:0]      cmd_arg,
  input  logic [DIV_W-1:0] div_half,
  output logic             done,
  output logic [7:0]       reply,
  output logic             timeout,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int PW = $clog2(MAX_POLL + 1);
  localparam logic [2:0] LAST_FRAME = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_POLL, S_TRAIL} state_t;

  state_t           state;
  logic [5:0]       idx_q;
  logic [31:0]      arg_q;
  logic [2:0]       byte_idx;
  logic [2:0]       bit_cnt;
  logic [PW-1:0]    poll_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       tx;
  logic [7:0]       rx;
  logic [6:0]       crc;
  logic [7:0]       nxt_byte;
  logic [7:0]       first_byte;

  function automatic logic [6:0] crc7_byte(input logic [6:0] c_in, input logic [7:0] b);
    logic [6:0] c;
    logic       top;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      top = c[6];
      c = {c[5:0], b[i]};
      if (top) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [6:0] crc7_aug(input logic [6:0] c_in);
    logic [6:0] c;
    logic       top;
    c = c_in;
    for (int i = 0; i < 7; i++) begin
      top = c[6];
      c = {c[5:0], 1'b0};
      if (top) c = c ^ 7'h09;
    end
    return c;
  endfunction

  assign first_byte = {2'b01, cmd_idx};
  assign spi_mosi   = tx[7];

  always_comb begin
    case (byte_idx)
      3'd0:    nxt_byte = arg_q[31:24];
      3'd1:    nxt_byte = arg_q[23:16];
      3'd2:    nxt_byte = arg_q[15:8];
      3'd3:    nxt_byte = arg_q[7:0];
      default: nxt_byte = {crc7_aug(crc), 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx_q    <= '0;
      arg_q    <= '0;
      byte_idx <= '0;
      bit_cnt  <= '0;
      poll_cnt <= '0;
      div_cnt  <= '0;
      tx       <= 8'hFF;
      rx       <= 8'hFF;
      crc      <= '0;
      done     <= 1'b0;
      reply    <= 8'hFF;
      timeout  <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          state    <= S_CMD;
          idx_q    <= cmd_idx;
          arg_q    <= cmd_arg;
          byte_idx <= '0;
          bit_cnt  <= '0;
          div_cnt  <= div_half;
          tx       <= first_byte;
          crc      <= crc7_byte(7'd0, first_byte);
          reply    <= 8'hFF;
          timeout  <= 1'b0;
          spi_cs_n <= 1'b0;
          spi_sck  <= 1'b0;
        end
      end else if (div_cnt != '0) begin
        div_cnt <= div_cnt - 1'b1;
      end else begin
        div_cnt <= div_half;
        spi_sck <= ~spi_sck;
        if (!spi_sck) begin
          rx <= {rx[6:0], spi_miso};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          tx      <= {tx[6:0], 1'b1};
          if (bit_cnt == 3'd7) begin
            case (state)
              S_CMD: begin
                if (byte_idx == LAST_FRAME) begin
                  state    <= S_POLL;
                  poll_cnt <= '0;
                  tx       <= 8'hFF;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                  tx       <= nxt_byte;
                  if (byte_idx < 3'd4) crc <= crc7_byte(crc, nxt_byte);
                end
              end
              S_POLL: begin
                tx <= 8'hFF;
                if (!rx[7]) begin
                  reply    <= rx;
                  state    <= S_TRAIL;
                  spi_cs_n <= 1'b1;
                end else if (poll_cnt == PW'(MAX_POLL - 1)) begin
                  reply    <= 8'hFF;
                  timeout  <= 1'b1;
                  state    <= S_TRAIL;
                  spi_cs_n <= 1'b1;
                end else begin
                  poll_cnt <= poll_cnt + 1'b1;
                end
              end
              default: begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_TRAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n) ($rose(spi_sck) && spi_cs_n) |-> spi_mosi); // R9
  AST_CS_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(spi_cs_n) |-> !spi_sck); // R9
  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE) |-> !spi_sck); // R5
  AST_TIMEOUT_VAL: assert property (@(posedge clk) disable iff (!rst_n) (done && timeout) |-> (reply == 8'hFF)); // R8
  AST_REPLY_MSB: assert property (@(posedge clk) disable iff (!rst_n) (done && !timeout) |-> !reply[7]); // R7
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE && !start) |=> ($stable(reply) && $stable(timeout))); // R10
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state == S_POLL) |-> (poll_cnt < PW'(MAX_POLL))); // R8

endmodule

// File: tb/sd_cmd_framer_tb.sv
module sd_cmd_framer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  div_half = '0;
  logic        done;
  logic [7:0]  reply;
  logic        timeout;
  logic        spi_cs_n;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso;

  int vectors = 0;
  int errors = 0;

  logic [0:255] stream = '1;
  int kbit = 0;
  int k0 = 0;
  int nlow = 0;
  int nlow0 = 0;
  int ntrail = 0;
  int trail_bad = 0;
  int hi_run = 0;
  int last_hi = 0;
  logic mbits [0:255];
  int sidx;

  always #2.5 clk = ~clk;

  sd_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .div_half(div_half), .done(done), .reply(reply), .timeout(timeout),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  assign sidx = kbit - k0;
  assign spi_miso = spi_cs_n ? 1'b1 : ((sidx >= 0 && sidx < 256) ? stream[sidx[7:0]] : 1'b1);

  always @(negedge spi_sck) if (!spi_cs_n) kbit++;

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if ((nlow - nlow0) >= 0 && (nlow - nlow0) < 256) mbits[nlow - nlow0] = spi_mosi;
      nlow++;
    end else begin
      ntrail++;
      if (!spi_mosi) trail_bad++;
    end
  end

  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else if (hi_run != 0) begin
      last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = '0;
    logic fb;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] cap_byte(input int j);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = mbits[j*8+k];
    return b;
  endfunction

  task automatic run_txn(input logic [5:0] ci, input logic [31:0] ca, input int delay,
                         input logic [7:0] rv, input logic [7:0] fill, input int dv);
    logic [47:0] frame;
    int npoll;
    int t0;
    int guard;
    logic [7:0] b;
    frame[47:40] = {2'b01, ci};
    frame[39:8]  = ca;
    frame[7:0]   = {ref_crc(frame[47:8]), 1'b1};
    for (int j = 0; j < 32; j++) begin
      if (j < 6) b = fill;
      else if (j < 6 + delay) b = 8'h80 | 8'((j * 37) & 8'h7F);
      else if (j == 6 + delay) b = rv;
      else b = 8'hFF;
      for (int k = 0; k < 8; k++) stream[j*8+k] = b[7-k];
    end
    npoll = (delay < 8) ? delay + 1 : 8;
    @(negedge clk);
    k0 = kbit;
    nlow0 = nlow;
    t0 = ntrail;
    trail_bad = 0;
    div_half = 8'(dv);
    cmd_idx = ci;
    cmd_arg = ca;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    cmd_idx = ~ci;
    cmd_arg = ~ca;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check("R10 done seen", int'(done), 1);
    for (int j = 0; j < 6; j++) begin
      if (j == 0) check("R2 first byte", int'(cap_byte(0)), int'(frame[47:40]));
      else if (j < 5) check("R3 argument byte (R11 latch)", int'(cap_byte(j)), int'(frame[47-8*j -: 8]));
      else check("R4 crc byte", int'(cap_byte(5)), int'(frame[7:0]));
    end
    if (ci == 6'd0 && ca == 32'd0) check("R4 known crc", int'(cap_byte(5)), 8'h95);
    for (int j = 0; j < npoll; j++) check("R6 poll byte", int'(cap_byte(6 + j)), 8'hFF);
    check("R7 R8 low-cs clocks", nlow - nlow0, 8 * (6 + npoll));
    check("R7 reply", int'(reply), (delay < 8) ? int'(rv) : 8'hFF);
    check("R8 timeout", int'(timeout), (delay < 8) ? 0 : 1);
    check("R9 trailing clocks", ntrail - t0, 8);
    check("R9 trailing mosi", trail_bad, 0);
    check("R5 sck high phase", last_hi, dv + 1);
    @(negedge clk);
    check("R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R10 reply held", int'(reply), (delay < 8) ? int'(rv) : 8'hFF);
    check("R9 cs idle high", int'(spi_cs_n), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [5:0]  cl [0:5];
    logic [31:0] al [0:5];
    int n;
    cl[0] = 6'd0;  al[0] = 32'h0000_0000;
    cl[1] = 6'd8;  al[1] = 32'h0000_01AA;
    cl[2] = 6'd17; al[2] = 32'h0000_0200;
    cl[3] = 6'd41; al[3] = 32'h4000_0000;
    cl[4] = 6'd55; al[4] = 32'h1234_5678;
    cl[5] = 6'd63; al[5] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 cs_n", int'(spi_cs_n), 1);
    check("R1 sck", int'(spi_sck), 0);
    check("R1 mosi", int'(spi_mosi), 1);
    check("R1 done", int'(done), 0);
    check("R1 timeout", int'(timeout), 0);
    check("R1 reply", int'(reply), 8'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n = 0;
    for (int c = 0; c < 6; c++) begin
      for (int d = 0; d < 10; d++) begin
        run_txn(cl[c], al[c], d, 8'((n * 29) & 8'h7F), (n % 2 == 1) ? 8'h00 : 8'hFF, n % 3);
        n++;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule